// File: doc/BRIEF.md
# Dual-Mask Interrupt Controller

This block gathers a vector of level-sensitive interrupt sources and drives two processor interrupt lines: a normal request line and a fast request line. Each line has its own enable mask. Software never rewrites a mask as a whole. It sets bits through one strobe register and clears bits through another, so two agents can change different bits without a read-modify-write race.

The controller sits on a simple synchronous register bus with an address, a write strobe, write data and combinational read data. Software can read the raw source levels, the masked status for each line and both enable masks. A mask it has read can be put back later by clearing everything and then writing the saved value to the set register. Only the low sources, given by a parameter, are implemented. Enable bits above them cannot be set and read as zero.

Top module: `dual_mask_intc`

## Requirements
- R1: Only source bits 0 to 21 (NUM_SRC = 22) exist. A write to a set register leaves enable bits 22 to 31 at zero, and every readable register returns zero in bits 22 to 31.
- R2: Writing to the normal-line set register (address 3) sets each enable bit whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R3: Writing to the normal-line clear register (address 4) clears each enable bit whose write-data bit is 1 and leaves the others unchanged. Writing all ones disables every source.
- R4: The fast-line mask has its own set register (address 7) and clear register (address 8), with the same semantics as R2 and R3. A write to one line's mask never changes the other line's mask.
- R5: The normal-line enable mask reads at address 2 and the fast-line mask reads at address 6. Writing a saved value to the set register after a full clear restores the mask exactly.
- R6: Address 0 reads the raw source inputs. Address 1 reads source AND normal enable. Address 5 reads source AND fast enable.
- R7: irq_o is the OR of the normal-line status bits and fiq_o is the OR of the fast-line status bits. Both are registered, so each follows a change of sources or masks one clock edge later.
- R8: After reset both masks are zero, and irq_o and fiq_o are low even while every source is active.
- R9: Writes to the readable addresses (0, 1, 2, 5, 6) and to unmapped addresses change no state. The set and clear registers (3, 4, 7, 8) read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| src_in | input | NUM_SRC (22) | Level-sensitive interrupt sources |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
A table of vectors drives sources and mask writes together. It pairs enabled sources with disabled ones, single bits with the full valid field, and the top valid bit 21 with write data that has only invalid bits set. These cases show correct masking apart from plain pass-through, and the 22-bit boundary apart from a full 32-bit mask. Other vectors set one line while the other is active, clear with all ones, or write zero data to a strobe. These show that the two masks are independent and that a zero bit really has no effect. Directed tests cover the reset state with every source active, a save-and-restore of a mask, read-only and unmapped writes, and the one-cycle delay of the outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;

   // Register word addresses. The numeric codes are part of the bus contract.
   typedef enum logic [3:0] {
      REG_RAW      = 4'd0,
      REG_IRQ_STAT = 4'd1,
      REG_IRQ_EN   = 4'd2,
      REG_IRQ_SET  = 4'd3,
      REG_IRQ_CLR  = 4'd4,
      REG_FIQ_STAT = 4'd5,
      REG_FIQ_EN   = 4'd6,
      REG_FIQ_SET  = 4'd7,
      REG_FIQ_CLR  = 4'd8
   } intc_reg_e;

   localparam int NUM_CH = 2;   // channel 0: normal line, channel 1: fast line
   localparam int CODE_W = 4;

   function automatic logic [CODE_W-1:0] set_code(input int ch);
      return (ch == 0) ? REG_IRQ_SET : REG_FIQ_SET;
   endfunction

   function automatic logic [CODE_W-1:0] clr_code(input int ch);
      return (ch == 0) ? REG_IRQ_CLR : REG_FIQ_CLR;
   endfunction

endpackage

// File: rtl/intc_mask_bank.sv
module intc_mask_bank #(
   parameter int               NUM_SRC    = 22,
   parameter int               DATA_W     = 32,
   parameter logic [NUM_SRC-1:0] VALID_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_stb,
   input  logic               clr_stb,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SRC-1:0] mask
);

   logic [NUM_SRC-1:0] wbits;
   logic [NUM_SRC-1:0] mask_nxt;

   assign wbits = wdata[NUM_SRC-1:0];

   always_comb begin
      mask_nxt = mask;
      if (set_stb) mask_nxt = mask_nxt | (wbits & VALID_MASK);
      if (clr_stb) mask_nxt = mask_nxt & ~wbits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= '0;
      else        mask <= mask_nxt;
   end

   // R2: every valid bit written as 1 is enabled after a set strobe
   assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb && !clr_stb) |=> ((mask & $past(wbits & VALID_MASK)) == $past(wbits & VALID_MASK)));

   // R2/R3: bits written as 0 keep their old value under either strobe
   assert_zero_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_stb || clr_stb) |=> ((mask & ~$past(wbits)) == ($past(mask) & ~$past(wbits))));

   // R3: every bit written as 1 is disabled after a clear strobe
   assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((mask & $past(wbits)) == '0));

   // R9: without a strobe the mask holds
   assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_stb && !clr_stb) |=> $stable(mask));

   // R1: invalid sources never become enabled
   assert_valid_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((mask & ~VALID_MASK) == ($past(mask) & ~VALID_MASK)));

endmodule

// File: rtl/intc_status_merge.sv
module intc_status_merge #(
   parameter int NUM_SRC = 22,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic [NUM_SRC-1:0] mask,
   output logic [NUM_SRC-1:0] status,
   output logic               req
);

   logic any_pending;

   assign status      = src & mask;
   assign any_pending = |status;

   generate
      if (OUT_REG) begin : g_reg
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= any_pending;
         end
         assign req = req_q;
      end else begin : g_comb
         assign req = any_pending;
      end
   endgenerate

endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 22,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_SRC-1:0] raw,
   input  logic [NUM_SRC-1:0] irq_stat,
   input  logic [NUM_SRC-1:0] irq_mask,
   input  logic [NUM_SRC-1:0] fiq_stat,
   input  logic [NUM_SRC-1:0] fiq_mask,
   output logic [DATA_W-1:0]  rdata
);

   logic [NUM_SRC-1:0] sel;

   always_comb begin
      sel = '0;
      if      (addr == ADDR_W'(REG_RAW))      sel = raw;
      else if (addr == ADDR_W'(REG_IRQ_STAT)) sel = irq_stat;
      else if (addr == ADDR_W'(REG_IRQ_EN))   sel = irq_mask;
      else if (addr == ADDR_W'(REG_FIQ_STAT)) sel = fiq_stat;
      else if (addr == ADDR_W'(REG_FIQ_EN))   sel = fiq_mask;
   end

   // Upper bits beyond the source field are always zero
   assign rdata = DATA_W'(sel);

endmodule

// File: rtl/dual_mask_intc.sv
module dual_mask_intc
   import intc_pkg::*;
#(
   parameter int                 NUM_SRC    = 22,
   parameter int                 DATA_W     = 32,
   parameter int                 ADDR_W     = 4,
   parameter logic [NUM_SRC-1:0] VALID_MASK = '1,
   parameter bit                 OUT_REG    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic               irq_o,
   output logic               fiq_o
);

   generate
      if (NUM_SRC > DATA_W || NUM_SRC < 1) begin : g_bad_src
         $error("dual_mask_intc: NUM_SRC must lie in 1..DATA_W");
      end
      if (ADDR_W < CODE_W) begin : g_bad_addr
         $error("dual_mask_intc: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_SRC-1:0] ch_mask [NUM_CH];
   logic [NUM_SRC-1:0] ch_stat [NUM_CH];
   logic               ch_req  [NUM_CH];

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic set_hit;
         logic clr_hit;

         assign set_hit = bus_wr && (bus_addr == ADDR_W'(set_code(ch)));
         assign clr_hit = bus_wr && (bus_addr == ADDR_W'(clr_code(ch)));

         intc_mask_bank #(
            .NUM_SRC    (NUM_SRC),
            .DATA_W     (DATA_W),
            .VALID_MASK (VALID_MASK)
         ) u_mask (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_hit),
            .clr_stb (clr_hit),
            .wdata   (bus_wdata),
            .mask    (ch_mask[ch])
         );

         intc_status_merge #(
            .NUM_SRC (NUM_SRC),
            .OUT_REG (OUT_REG)
         ) u_merge (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_in),
            .mask   (ch_mask[ch]),
            .status (ch_stat[ch]),
            .req    (ch_req[ch])
         );
      end
   endgenerate

   intc_read_mux #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_rmux (
      .addr     (bus_addr),
      .raw      (src_in),
      .irq_stat (ch_stat[0]),
      .irq_mask (ch_mask[0]),
      .fiq_stat (ch_stat[1]),
      .fiq_mask (ch_mask[1]),
      .rdata    (bus_rdata)
   );

   assign irq_o = ch_req[0];
   assign fiq_o = ch_req[1];

   generate
      if (OUT_REG) begin : g_out_chk
         // R7: the request line follows the status read on the previous cycle
         assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_W'(REG_IRQ_STAT)) |=> (irq_o == ($past(bus_rdata) != '0)));

         assert_fiq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_W'(REG_FIQ_STAT)) |=> (fiq_o == ($past(bus_rdata) != '0)));
      end
   endgenerate

   // R1: read data never carries bits above the source field
   always_comb begin
      if (rst_n) assert_upper_zero_R1: assert ((bus_rdata >> NUM_SRC) == '0);
   end

endmodule

// File: tb/dual_mask_intc_tb.sv
module dual_mask_intc_tb;

   localparam int NS = 22;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [NS-1:0] src_in = '0;
   logic          irq_o;
   logic          fiq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dual_mask_intc u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .src_in    (src_in),
      .irq_o     (irq_o),
      .fiq_o     (fiq_o)
   );

   typedef struct packed {
      logic [3:0]  a;
      logic [31:0] wd;
      logic [21:0] src;
      logic [31:0] ie;
      logic [31:0] fe;
      logic        eirq;
      logic        efiq;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{4'd3, 32'h0000_0005, 22'h000001, 32'h0000_0005, 32'h0,         1'b1, 1'b0},
      '{4'd3, 32'hFFC0_0000, 22'h000002, 32'h0000_0005, 32'h0,         1'b0, 1'b0},
      '{4'd3, 32'h0000_0002, 22'h000002, 32'h0000_0007, 32'h0,         1'b1, 1'b0},
      '{4'd4, 32'h0000_0001, 22'h000001, 32'h0000_0006, 32'h0,         1'b0, 1'b0},
      '{4'd7, 32'h0020_0000, 22'h200000, 32'h0000_0006, 32'h0020_0000, 1'b0, 1'b1},
      '{4'd3, 32'h0020_0000, 22'h200000, 32'h0020_0006, 32'h0020_0000, 1'b1, 1'b1},
      '{4'd8, 32'hFFFF_FFFF, 22'h200000, 32'h0020_0006, 32'h0,         1'b1, 1'b0},
      '{4'd4, 32'hFFFF_FFFF, 22'h3FFFFF, 32'h0,         32'h0,         1'b0, 1'b0},
      '{4'd0, 32'hFFFF_FFFF, 22'h000000, 32'h0,         32'h0,         1'b0, 1'b0},
      '{4'd3, 32'h003F_FFFF, 22'h3FFFFF, 32'h003F_FFFF, 32'h0,         1'b1, 1'b0},
      '{4'd7, 32'h0000_0400, 22'h000000, 32'h003F_FFFF, 32'h0000_0400, 1'b0, 1'b0},
      '{4'd3, 32'h0000_0000, 22'h100000, 32'h003F_FFFF, 32'h0000_0400, 1'b1, 1'b0},
      '{4'd4, 32'h0000_0000, 22'h000400, 32'h003F_FFFF, 32'h0000_0400, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] saved;

      // R8: reset with every source active
      src_in = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      bus_read(4'd2, rd); chk("R8 irq mask after reset", rd, 32'h0);
      bus_read(4'd6, rd); chk("R8 fiq mask after reset", rd, 32'h0);
      chk("R8 irq_o after reset", {31'b0, irq_o}, 32'h0);
      chk("R8 fiq_o after reset", {31'b0, fiq_o}, 32'h0);
      bus_read(4'd0, rd); chk("R6 raw after reset", rd, 32'h003F_FFFF);

      // Table walk: R1..R7
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         src_in = VEC[i].src;
         bus_write(VEC[i].a, VEC[i].wd);
         @(negedge clk);
         bus_read(4'd2, rd); chk($sformatf("R2 R3 R1 irq mask v%0d", i), rd, VEC[i].ie);
         bus_read(4'd6, rd); chk($sformatf("R4 fiq mask v%0d", i), rd, VEC[i].fe);
         bus_read(4'd0, rd); chk($sformatf("R6 raw v%0d", i), rd, 32'(VEC[i].src));
         bus_read(4'd1, rd); chk($sformatf("R6 irq status v%0d", i), rd, 32'(VEC[i].src) & VEC[i].ie);
         bus_read(4'd5, rd); chk($sformatf("R6 fiq status v%0d", i), rd, 32'(VEC[i].src) & VEC[i].fe);
         chk($sformatf("R7 irq_o v%0d", i), {31'b0, irq_o}, {31'b0, VEC[i].eirq});
         chk($sformatf("R7 fiq_o v%0d", i), {31'b0, fiq_o}, {31'b0, VEC[i].efiq});
      end

      // R9: strobe registers read as zero
      bus_read(4'd3, rd); chk("R9 irq set reads zero", rd, 32'h0);
      bus_read(4'd4, rd); chk("R9 irq clear reads zero", rd, 32'h0);
      bus_read(4'd7, rd); chk("R9 fiq set reads zero", rd, 32'h0);
      bus_read(4'd8, rd); chk("R9 fiq clear reads zero", rd, 32'h0);

      // R9: writes to enable readback and unmapped addresses are ignored
      bus_write(4'd2, 32'h0);
      bus_write(4'd6, 32'hFFFF_FFFF);
      bus_write(4'd15, 32'hFFFF_FFFF);
      @(negedge clk);
      bus_read(4'd2, rd); chk("R9 irq mask unchanged", rd, 32'h003F_FFFF);
      bus_read(4'd6, rd); chk("R9 fiq mask unchanged", rd, 32'h0000_0400);

      // R5: save, clear all, restore through set register
      bus_read(4'd2, saved);
      bus_write(4'd4, 32'hFFFF_FFFF);
      bus_read(4'd2, rd); chk("R3 full clear", rd, 32'h0);
      bus_write(4'd3, 32'h0000_0000);
      bus_write(4'd3, saved & 32'h0012_3456);
      bus_read(4'd2, rd); chk("R5 partial restore", rd, 32'h0012_3456);
      bus_write(4'd4, 32'hFFFF_FFFF);
      bus_write(4'd3, saved);
      bus_read(4'd2, rd); chk("R5 restore", rd, saved);

      // R7: outputs lag source changes by one edge
      src_in = '0;
      @(negedge clk);
      @(negedge clk);
      chk("R7 irq_o idle", {31'b0, irq_o}, 32'h0);
      src_in = 22'h000400;
      #1;
      chk("R7 fiq_o before edge", {31'b0, fiq_o}, 32'h0);
      chk("R7 irq_o before edge", {31'b0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R7 fiq_o after edge", {31'b0, fiq_o}, 32'h1);
      chk("R7 irq_o after edge", {31'b0, irq_o}, 32'h1);
      src_in = '0;
      @(negedge clk);
      chk("R7 fiq_o falls", {31'b0, fiq_o}, 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule